// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator

This block maps a virtual address and an access size onto a physical address. A build-time switch chooses how it looks up the mapping. One choice is a small fully associative set of translation entries that software fills. The other is a linear table indexed directly by the virtual page number. Each entry carries a valid flag, a virtual page number (used only in associative mode), a physical frame number, a write-protect flag, and "referenced" and "modified" flags that the hardware maintains.

A request is presented for one cycle. One cycle later the block returns a registered response holding a result code and, on success, the physical address. The checks run in a fixed priority order: alignment, then page range and presence, then write protection, then frame bound. The first failing check sets the code. A successful access marks its entry referenced, and also modified when it is a write. Software refills entries through a fill port. A probe port reads back an entry's referenced and modified flags so the refill code can choose what to replace.

Top module: `xlat_unit`

## Requirements
- R1: A word access (size code 2 or 3) with either of address bits 1:0 set, or a half-word access (size code 1) with address bit 0 set, returns code 1 (address error). This check wins over every other check. Byte accesses (size code 0) are never misaligned.
- R2: The virtual page number is the address above the low OFF_W offset bits. On success the physical address is the frame number concatenated with those offset bits, which equals frame × page size + offset.
- R3: In linear-table mode, a page number at or beyond PT_ENTRIES returns code 1 (address error), and an in-range entry whose valid flag is clear returns code 2 (page fault).
- R4: In associative mode, all valid entries are compared against the page number and the lowest-index match supplies the translation. When nothing matches, the result is code 2 (page fault).
- R5: A write that hits an entry with its write-protect flag set returns code 3 (protection error). A read of the same entry succeeds.
- R6: A frame number at or above NUM_PHYS_PAGES returns code 4 (bus error), after the protection check.
- R7: Only an access that returns code 0 (success) sets the entry's referenced flag, and it sets the modified flag only when the access is a write. An access that fails changes neither flag.
- R8: After reset every entry is invalid, no response is pending, and the first lookup faults.
- R9: The response (resp_valid, code, address) appears exactly one cycle after the request. The address is zero whenever the code is not 0.
- R10: A fill writes the entry's valid flag, page number, frame number and write-protect flag, and clears its referenced and modified flags. If a fill and a flag update target the same entry in the same cycle, the fill wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | VA_W | Virtual address |
| req_size | input | 2 | 0 byte, 1 half-word, 2 or 3 word |
| req_write | input | 1 | Access is a write |
| fill_en | input | 1 | Write an entry |
| fill_idx | input | IDX_W | Entry to write |
| fill_valid | input | 1 | Valid flag for the entry |
| fill_vpn | input | VPN_W | Virtual page number (associative mode) |
| fill_pfn | input | PFN_W | Physical frame number |
| fill_ro | input | 1 | Write-protect flag |
| probe_idx | input | IDX_W | Entry whose flags are read back |
| probe_used | output | 1 | Referenced flag of the probed entry (combinational) |
| probe_dirty | output | 1 | Modified flag of the probed entry (combinational) |
| resp_valid | output | 1 | Response strobe |
| resp_code | output | 3 | 0 ok, 1 address error, 2 page fault, 3 protection, 4 bus error |
| resp_paddr | output | PFN_W+OFF_W | Physical address, zero on error |

## Verification
Every lookup result is due on the cycle after the edge that sampled the request. The driver queues the expected code and address in the same cycle that it raises the request. The monitor pops the queue only on cycles where resp_valid is high, and it samples on the falling edge. A response with no queued entry counts as a failure, and so does an entry left in the queue at the end. The flag updates and fills take effect at the same edge as the response, so the bench reads the probe outputs on the falling edge after a response and before the next request.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    XC_OK    = 3'd0,
    XC_ALIGN = 3'd1,
    XC_FAULT = 3'd2,
    XC_PROT  = 3'd3,
    XC_BUS   = 3'd4
  } xlat_code_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WRD3 = 2'd3
  } xlat_size_e;
endpackage

// File: rtl/xlat_entry_file.sv
module xlat_entry_file #(
  parameter int N     = 4,
  parameter int VPN_W = 24,
  parameter int PFN_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      fill_en,
  input  logic [IDX_W-1:0]          fill_idx,
  input  logic                      fill_valid,
  input  logic [VPN_W-1:0]          fill_vpn,
  input  logic [PFN_W-1:0]          fill_pfn,
  input  logic                      fill_ro,
  input  logic                      upd_en,
  input  logic [IDX_W-1:0]          upd_idx,
  input  logic                      upd_write,
  input  logic [IDX_W-1:0]          probe_idx,
  output logic                      probe_used,
  output logic                      probe_dirty,
  output logic [N-1:0]              valid_o,
  output logic [N-1:0][VPN_W-1:0]   vpn_o,
  output logic [N-1:0][PFN_W-1:0]   pfn_o,
  output logic [N-1:0]              ro_o
);
  logic [N-1:0]            valid_q, ro_q, used_q, dirty_q;
  logic [N-1:0][VPN_W-1:0] vpn_q;
  logic [N-1:0][PFN_W-1:0] pfn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        valid_q[i] <= 1'b0;
        ro_q[i]    <= 1'b0;
        used_q[i]  <= 1'b0;
        dirty_q[i] <= 1'b0;
        vpn_q[i]   <= '0;
        pfn_q[i]   <= '0;
      end
    end else begin
      if (upd_en) begin
        used_q[upd_idx] <= 1'b1;
        if (upd_write) dirty_q[upd_idx] <= 1'b1;
      end
      if (fill_en) begin
        valid_q[fill_idx] <= fill_valid;
        vpn_q[fill_idx]   <= fill_vpn;
        pfn_q[fill_idx]   <= fill_pfn;
        ro_q[fill_idx]    <= fill_ro;
        used_q[fill_idx]  <= 1'b0;
        dirty_q[fill_idx] <= 1'b0;
      end
    end
  end

  assign valid_o     = valid_q;
  assign vpn_o       = vpn_q;
  assign pfn_o       = pfn_q;
  assign ro_o        = ro_q;
  assign probe_used  = used_q[probe_idx];
  assign probe_dirty = dirty_q[probe_idx];

  // R10: a fill leaves the entry unreferenced and unmodified
  a_r10_fill_clears: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> (!used_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]));
  // R7: the modified flag is never set without the referenced flag
  a_r7_dirty_implies_used: assert property (@(posedge clk) disable iff (rst)
    (dirty_q & ~used_q) == '0);
endmodule

// File: rtl/xlat_assoc_find.sv
module xlat_assoc_find #(
  parameter int N     = 4,
  parameter int VPN_W = 24,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [VPN_W-1:0]        vpn,
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][VPN_W-1:0] vpn_i,
  output logic                    hit,
  output logic                    range_err,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] match_vec;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = valid_i[g] && (vpn_i[g] == vpn);
  end

  // walk from the top so the lowest matching index is the one kept
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assign range_err = 1'b0;

  // R4: a hit is reported exactly when some entry matches
  a_r4_hit_iff_match: assert property (@(posedge clk) disable iff (rst)
    hit == (|match_vec));
  // R4: the chosen entry matches and no lower index matches
  a_r4_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    hit |-> (match_vec[idx] && ((match_vec & ((N'(1) << idx) - N'(1))) == '0)));
endmodule

// File: rtl/xlat_direct_find.sv
module xlat_direct_find #(
  parameter int N     = 16,
  parameter int VPN_W = 24,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [VPN_W-1:0]   vpn,
  input  logic [N-1:0]       valid_i,
  output logic               hit,
  output logic               range_err,
  output logic [IDX_W-1:0]   idx
);
  assign range_err = (vpn >= VPN_W'(N));
  assign idx       = vpn[IDX_W-1:0];
  assign hit       = !range_err && valid_i[idx];

  // R3: a page number past the table never produces a hit
  a_r3_no_hit_out_of_range: assert property (@(posedge clk) disable iff (rst)
    range_err |-> !hit);
endmodule

// File: rtl/xlat_check.sv
module xlat_check
  import xlat_pkg::*;
#(
  parameter int PFN_W          = 8,
  parameter int NUM_PHYS_PAGES = 16
) (
  input  logic [1:0]       size,
  input  logic [1:0]       addr_lo,
  input  logic             write,
  input  logic             range_err,
  input  logic             hit,
  input  logic             ro,
  input  logic [PFN_W-1:0] pfn,
  output xlat_code_e       code
);
  logic misaligned;

  always_comb begin
    unique case (xlat_size_e'(size))
      SZ_BYTE:          misaligned = 1'b0;
      SZ_HALF:          misaligned = addr_lo[0];
      SZ_WORD, SZ_WRD3: misaligned = |addr_lo;
      default:          misaligned = 1'b0;
    endcase
  end

  always_comb begin
    if (misaligned)                          code = XC_ALIGN;
    else if (range_err)                      code = XC_ALIGN;
    else if (!hit)                           code = XC_FAULT;
    else if (ro && write)                    code = XC_PROT;
    else if ({1'b0, pfn} >= (PFN_W+1)'(NUM_PHYS_PAGES)) code = XC_BUS;
    else                                     code = XC_OK;
  end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
  import xlat_pkg::*;
#(
  parameter int USE_TLB        = 1,
  parameter int VA_W           = 32,
  parameter int OFF_W          = 8,
  parameter int PFN_W          = 8,
  parameter int NUM_PHYS_PAGES = 16,
  parameter int TLB_ENTRIES    = 4,
  parameter int PT_ENTRIES     = 16,
  localparam int VPN_W   = VA_W - OFF_W,
  localparam int PA_W    = PFN_W + OFF_W,
  localparam int ENTRIES = (USE_TLB != 0) ? TLB_ENTRIES : PT_ENTRIES,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_ro,
  input  logic [IDX_W-1:0] probe_idx,
  output logic             probe_used,
  output logic             probe_dirty,
  output logic             resp_valid,
  output logic [2:0]       resp_code,
  output logic [PA_W-1:0]  resp_paddr
);
  logic [VPN_W-1:0] vpn;
  logic [OFF_W-1:0] offset;
  assign vpn    = req_vaddr[VA_W-1:OFF_W];
  assign offset = req_vaddr[OFF_W-1:0];

  logic [ENTRIES-1:0]            valid_tab, ro_tab;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_tab;
  logic [ENTRIES-1:0][PFN_W-1:0] pfn_tab;
  logic                          hit, range_err;
  logic [IDX_W-1:0]              sel;
  xlat_code_e                    code;
  logic                          upd_en;

  assign upd_en = req_valid && (code == XC_OK);

  xlat_entry_file #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_entries (
    .clk, .rst,
    .fill_en, .fill_idx, .fill_valid, .fill_vpn, .fill_pfn, .fill_ro,
    .upd_en, .upd_idx(sel), .upd_write(req_write),
    .probe_idx, .probe_used, .probe_dirty,
    .valid_o(valid_tab), .vpn_o(vpn_tab), .pfn_o(pfn_tab), .ro_o(ro_tab)
  );

  if (USE_TLB != 0) begin : g_assoc
    xlat_assoc_find #(.N(ENTRIES), .VPN_W(VPN_W)) u_find (
      .clk, .rst, .vpn, .valid_i(valid_tab), .vpn_i(vpn_tab),
      .hit, .range_err, .idx(sel)
    );
  end else begin : g_direct
    xlat_direct_find #(.N(ENTRIES), .VPN_W(VPN_W)) u_find (
      .clk, .rst, .vpn, .valid_i(valid_tab),
      .hit, .range_err, .idx(sel)
    );
  end

  xlat_check #(.PFN_W(PFN_W), .NUM_PHYS_PAGES(NUM_PHYS_PAGES)) u_check (
    .size(req_size), .addr_lo(req_vaddr[1:0]), .write(req_write),
    .range_err, .hit, .ro(ro_tab[sel]), .pfn(pfn_tab[sel]), .code
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_code  <= 3'd0;
      resp_paddr <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_code  <= code;
        resp_paddr <= (code == XC_OK) ? {pfn_tab[sel], offset} : '0;
      end
    end
  end

  // R1: misaligned word access yields an address error next cycle
  a_r1_word_align: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_size[1] && (req_vaddr[1:0] != 2'b00)) |=> (resp_code == 3'd1));
  // R9: a response follows a request by exactly one cycle
  a_r9_resp_timing: assert property (@(posedge clk) disable iff (rst)
    resp_valid == $past(req_valid));
  // R9: no address leaks out with an error code
  a_r9_zero_on_error: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code != 3'd0) |-> (resp_paddr == '0));
  // R2: a successful response keeps the request's page offset
  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && resp_code == 3'd0) |-> (resp_paddr[OFF_W-1:0] == $past(offset)));
endmodule

// File: tb/tb_xlat_unit.sv
module tb_xlat_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  typedef struct {
    logic [2:0]  code;
    logic [15:0] pa;
    string       tag;
  } exp_t;

  exp_t q_a[$];
  exp_t q_d[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        req_a, req_d, req_write, fill_a, fill_d, fill_valid, fill_ro;
  logic [31:0] req_vaddr;
  logic [1:0]  req_size;
  logic [23:0] fill_vpn;
  logic [7:0]  fill_pfn;
  logic [3:0]  fidx, pidx;
  logic        pu_a, pd_a, pu_d, pd_d, rv_a, rv_d;
  logic [2:0]  rc_a, rc_d;
  logic [15:0] pa_a, pa_d;

  xlat_unit #(.USE_TLB(1)) dut (
    .clk, .rst, .req_valid(req_a), .req_vaddr, .req_size, .req_write,
    .fill_en(fill_a), .fill_idx(fidx[1:0]), .fill_valid, .fill_vpn, .fill_pfn,
    .fill_ro, .probe_idx(pidx[1:0]), .probe_used(pu_a), .probe_dirty(pd_a),
    .resp_valid(rv_a), .resp_code(rc_a), .resp_paddr(pa_a));

  xlat_unit #(.USE_TLB(0)) dut_pt (
    .clk, .rst, .req_valid(req_d), .req_vaddr, .req_size, .req_write,
    .fill_en(fill_d), .fill_idx(fidx), .fill_valid, .fill_vpn, .fill_pfn,
    .fill_ro, .probe_idx(pidx), .probe_used(pu_d), .probe_dirty(pd_d),
    .resp_valid(rv_d), .resp_code(rc_d), .resp_paddr(pa_d));

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic compare(input exp_t e, input logic [2:0] c, input logic [15:0] p);
    check(c == e.code && p == e.pa,
          $sformatf("%s: got code %0d pa %h, expected code %0d pa %h",
                    e.tag, c, p, e.code, e.pa));
  endtask

  // monitors: pop one expected item per response
  always @(negedge clk) begin
    if (!rst && rv_a) begin
      if (q_a.size() == 0) check(0, "R9: unexpected response (assoc), got 1 expected 0");
      else compare(q_a.pop_front(), rc_a, pa_a);
    end
    if (!rst && rv_d) begin
      if (q_d.size() == 0) check(0, "R9: unexpected response (table), got 1 expected 0");
      else compare(q_d.pop_front(), rc_d, pa_d);
    end
  end

  task automatic lookup(input bit tbl, input logic [31:0] va, input logic [1:0] sz,
                        input bit wr, input logic [2:0] code, input logic [15:0] pa,
                        input string tag);
    exp_t e;
    e.code = code; e.pa = pa; e.tag = tag;
    @(negedge clk);
    req_vaddr = va; req_size = sz; req_write = wr;
    if (tbl) begin req_d = 1'b1; q_d.push_back(e); end
    else     begin req_a = 1'b1; q_a.push_back(e); end
    @(negedge clk);
    req_a = 1'b0; req_d = 1'b0;
  endtask

  task automatic fill(input bit tbl, input logic [3:0] idx, input bit v,
                      input logic [23:0] vpn, input logic [7:0] pfn, input bit ro);
    @(negedge clk);
    fidx = idx; fill_valid = v; fill_vpn = vpn; fill_pfn = pfn; fill_ro = ro;
    if (tbl) fill_d = 1'b1; else fill_a = 1'b1;
    @(negedge clk);
    fill_a = 1'b0; fill_d = 1'b0;
  endtask

  // read back flags on the associative instance at a falling edge
  task automatic probe(input logic [3:0] idx, input bit eu, input bit ed, input string tag);
    pidx = idx;
    #1;
    check(pu_a == eu && pd_a == ed,
          $sformatf("%s: flags used/dirty got %0d/%0d expected %0d/%0d",
                    tag, pu_a, pd_a, eu, ed));
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog: run hung, got timeout expected completion");
      report();
    end
  end

  initial begin
    req_a = 0; req_d = 0; req_write = 0; req_vaddr = 0; req_size = 0;
    fill_a = 0; fill_d = 0; fill_valid = 0; fill_vpn = 0; fill_pfn = 0;
    fill_ro = 0; fidx = 0; pidx = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: nothing pending, all entries invalid
    check(rv_a == 0 && rv_d == 0, $sformatf("R8: resp_valid after reset got %0d expected 0", rv_a));
    lookup(0, 32'h0000_0100, 2'd2, 0, 3'd2, 16'h0, "R8 first lookup faults (assoc)");
    lookup(1, 32'h0000_0100, 2'd2, 0, 3'd2, 16'h0, "R8 first lookup faults (table)");

    fill(0, 0, 1, 24'h12, 8'd3, 0);
    fill(0, 1, 1, 24'h12, 8'd5, 0);
    fill(0, 2, 1, 24'h40, 8'd7, 1);
    fill(0, 3, 1, 24'h50, 8'd20, 0);

    lookup(0, 32'h0000_1234, 2'd2, 0, 3'd0, 16'h0334, "R2/R4 lowest index wins");
    probe(0, 1, 0, "R7 read sets used only");
    probe(1, 0, 0, "R4 higher duplicate untouched");
    lookup(0, 32'h0000_12F0, 2'd1, 1, 3'd0, 16'h03F0, "R7 half write ok");
    probe(0, 1, 1, "R7 write sets dirty");
    lookup(0, 32'h0000_1232, 2'd2, 0, 3'd1, 16'h0, "R1 word misaligned");
    lookup(0, 32'h0000_1231, 2'd1, 0, 3'd1, 16'h0, "R1 half misaligned");
    lookup(0, 32'h0000_1231, 2'd0, 0, 3'd0, 16'h0331, "R1 byte never misaligned");
    lookup(0, 32'h0000_9902, 2'd3, 0, 3'd1, 16'h0, "R1 alignment before miss");
    lookup(0, 32'h0000_4010, 2'd2, 0, 3'd0, 16'h0710, "R5 read of protected page");
    lookup(0, 32'h0000_4010, 2'd2, 1, 3'd3, 16'h0, "R5 write to protected page");
    probe(2, 1, 0, "R7 failed write leaves dirty clear");
    lookup(0, 32'h0000_4011, 2'd2, 1, 3'd1, 16'h0, "R1 alignment before protection");
    lookup(0, 32'h0000_5000, 2'd2, 0, 3'd4, 16'h0, "R6 frame out of bound");
    lookup(0, 32'h0000_5000, 2'd2, 1, 3'd4, 16'h0, "R6 bus error on write");
    probe(3, 0, 0, "R7 bus error sets nothing");
    lookup(0, 32'h0000_7700, 2'd0, 0, 3'd2, 16'h0, "R4 no match faults");

    fill(0, 0, 1, 24'h60, 8'd1, 0);
    probe(0, 0, 0, "R10 fill clears flags");
    lookup(0, 32'h0000_1200, 2'd2, 0, 3'd0, 16'h0500, "R10 refill exposes next match");
    lookup(0, 32'h0000_60AC, 2'd2, 1, 3'd0, 16'h01AC, "R10 new mapping used");

    // linear table mode
    fill(1, 2, 1, 24'h0, 8'd9, 0);
    lookup(1, 32'h0000_0204, 2'd2, 0, 3'd0, 16'h0904, "R3/R2 table hit");
    lookup(1, 32'h0000_0300, 2'd2, 0, 3'd2, 16'h0, "R3 invalid entry faults");
    lookup(1, 32'h0000_1000, 2'd0, 0, 3'd1, 16'h0, "R3 page past table");
    lookup(1, 32'h0001_0204, 2'd0, 0, 3'd1, 16'h0, "R3 high page past table");

    // R9: response strobe drops when no request follows
    @(negedge clk);
    check(rv_a == 0 && rv_d == 0, $sformatf("R9: resp_valid idle got %0d expected 0", rv_a | rv_d));
    check(q_a.size() == 0 && q_d.size() == 0,
          $sformatf("R9: responses outstanding got %0d expected 0", q_a.size() + q_d.size()));
    done = 1;
    report();
  end
endmodule